// File: doc/BRIEF.md
# Sixteen-Channel Dual-Stage Hit Capture

This block records pulses that arrive on sixteen channel inputs. Each channel holds two cascaded capture flops. The first flop notes that at least one hit has arrived. The second notes a further hit that came while the first was already set. A channel therefore tells apart no hit, one hit and two or more hits. Hits come from asynchronous front-panel lines, which pass through a synchronizer and edge detector. They can also come from a software-written set vector, where each 0-to-1 bit transition counts as one hit.

Acceptance of front-panel hits can be limited per channel by an input mask. It can also be limited by a common gate, which has its own override. A mode input picks which flop stage drives each channel output. Per-channel force and suppress vectors then shape the outputs. The block also produces the OR and the NOR of the channel outputs, and a single control disables both of these. A global clear, from an asynchronous line or from a synchronous command, empties all capture flops and the stored software set vector.

Top module: `hit_capture_array`

## Requirements
- R1: While `rst` is high at a clock edge, `stage1`, `stage2`, `ch_out`, `or_out` and `nor_out` are all 0 after that edge.
- R2: A rising edge on `hit_in[i]` is accepted when `in_mask[i]` is 0 and the gate allows it. The channel's `stage1[i]` then becomes 1 at the third rising clock edge that samples the input high. `stage1[i]` stays 1 until a clear or a reset.
- R3: An accepted hit on a channel whose `stage1` bit is already 1 sets its `stage2` bit. Further hits leave both bits at 1. `stage2[i]` is never 1 while `stage1[i]` is 0.
- R4: `ch_out[i]` is registered one cycle after the stage flops. With `mode`=0 and no forcing or masking, it equals `stage1[i]`. With `mode`=1 it equals `stage2[i]`.
- R5: When `in_mask[i]` is 1, front-panel hits on channel i are ignored. A software set of channel i is still counted.
- R6: When `gate_mask` is 1, `gate_in` has no effect. When `gate_mask` is 0, front-panel hits count only while the synchronized `gate_in` is 1.
- R7: A cycle with `sw_set_we`=1 stores `sw_set_data`. Each bit that goes from 0 in the stored vector to 1 in the written value counts as one hit at that clock edge. Writing 1 over a stored 1 counts nothing, so writing 1, then 0, then 1 gives two hits.
- R8: `out_set[i]`=1 forces `ch_out[i]` to 1 whatever the stages hold. `out_mask[i]`=1 forces `ch_out[i]` to 0 unless `out_set[i]` is 1.
- R9: A `clear_cmd` pulse clears every stage flop and the stored software set vector at that clock edge. A `clear_in` pulse does the same once it has passed the synchronizer. A clear wins over a hit that arrives in the same cycle.
- R10: `or_out` is the OR of the `ch_out` bits and `nor_out` is their NOR. Both are registered in the same cycle as `ch_out`, and both are 0 while `or_mask` is 1.
- R11: `stage1` and `stage2` do not depend on `out_mask`, `out_set` or `mode`.
- R12: A front-panel hit edge and a software set edge on the same channel in the same clock cycle count as one hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 16 | Asynchronous channel hit lines |
| gate_in | input | 1 | Asynchronous common gate |
| clear_in | input | 1 | Asynchronous common clear |
| clear_cmd | input | 1 | Synchronous clear command pulse |
| in_mask | input | 16 | Per-channel front-panel hit mask (1 = ignore) |
| gate_mask | input | 1 | 1 = gate ignored, 0 = gate qualifies hits |
| sw_set_we | input | 1 | Write strobe for the software set vector |
| sw_set_data | input | 16 | Value written to the software set vector |
| mode | input | 1 | 0 = output from first stage, 1 = from second stage |
| out_set | input | 16 | Per-channel output force |
| out_mask | input | 16 | Per-channel output suppress |
| or_mask | input | 1 | 1 = disable `or_out` and `nor_out` |
| stage1 | output | 16 | First-stage (one hit) status |
| stage2 | output | 16 | Second-stage (two hits) status |
| ch_out | output | 16 | Registered channel outputs |
| or_out | output | 1 | OR of the channel outputs |
| nor_out | output | 1 | NOR of the channel outputs |

## Verification
The checks assume that every control input is synchronous to `clk` except `hit_in`, `gate_in` and `clear_in`. They also assume that a stage bit can fall only through `clear_cmd`, through a `clear_in` pulse a few cycles back, or through reset. The stimulus changes inputs only on falling clock edges. It holds each front-panel pulse high for two cycles and then low for at least four, so that every edge crosses the synchronizer cleanly. It also raises `gate_in` several cycles before the hits it is meant to qualify.

// File: rtl/hcap_pkg.sv
package hcap_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DOUBLE = 1'b1
  } hcap_mode_e;

  function automatic logic [15:0] pick16(input logic sel, input logic [15:0] a, input logic [15:0] b);
    return sel ? b : a;
  endfunction
endpackage

// File: rtl/hcap_sync.sv
module hcap_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hcap_channel.sv
module hcap_channel (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic first_q,
  output logic second_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else if (hit) begin
      first_q <= 1'b1;
      if (first_q) second_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hit_capture_array.sv
module hit_capture_array #(
  parameter int NCH         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hit_in,
  input  logic           gate_in,
  input  logic           clear_in,
  input  logic           clear_cmd,
  input  logic [NCH-1:0] in_mask,
  input  logic           gate_mask,
  input  logic           sw_set_we,
  input  logic [NCH-1:0] sw_set_data,
  input  logic           mode,
  input  logic [NCH-1:0] out_set,
  input  logic [NCH-1:0] out_mask,
  input  logic           or_mask,
  output logic [NCH-1:0] stage1,
  output logic [NCH-1:0] stage2,
  output logic [NCH-1:0] ch_out,
  output logic           or_out,
  output logic           nor_out
);
  import hcap_pkg::*;

  localparam int SW = NCH + 2;

  logic [SW-1:0]  sync_q;
  logic [NCH-1:0] hit_s, hit_prev, hw_acc, sw_q, sw_rise, hit_any, src, ch_next;
  logic           gate_s, clr_s, clear_all, gate_ok;
  hcap_mode_e     mode_e;

  hcap_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({clear_in, gate_in, hit_in}),
    .q   (sync_q)
  );

  assign hit_s     = sync_q[NCH-1:0];
  assign gate_s    = sync_q[NCH];
  assign clr_s     = sync_q[NCH+1];
  assign clear_all = clear_cmd | clr_s;
  assign gate_ok   = gate_mask | gate_s;

  always_ff @(posedge clk) begin
    if (rst) hit_prev <= '0;
    else     hit_prev <= hit_s;
  end

  assign hw_acc  = hit_s & ~hit_prev & ~in_mask & {NCH{gate_ok}};
  assign sw_rise = sw_set_we ? (sw_set_data & ~sw_q) : '0;
  assign hit_any = hw_acc | sw_rise;

  always_ff @(posedge clk) begin
    if (rst || clear_all) sw_q <= '0;
    else if (sw_set_we)   sw_q <= sw_set_data;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      hcap_channel u_ch (
        .clk      (clk),
        .rst      (rst),
        .clr      (clear_all),
        .hit      (hit_any[c]),
        .first_q  (stage1[c]),
        .second_q (stage2[c])
      );
    end
  endgenerate

  assign mode_e  = hcap_mode_e'(mode);
  assign src     = (mode_e == MODE_DOUBLE) ? stage2 : stage1;
  assign ch_next = out_set | (src & ~out_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_out  <= '0;
      or_out  <= 1'b0;
      nor_out <= 1'b0;
    end else begin
      ch_out  <= ch_next;
      or_out  <= ~or_mask & (|ch_next);
      nor_out <= ~or_mask & ~(|ch_next);
    end
  end
endmodule

// File: rtl/hcap_checker.sv
module hcap_checker #(
  parameter int NCH         = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           clear_in,
  input logic           clear_cmd,
  input logic           mode,
  input logic [NCH-1:0] out_set,
  input logic [NCH-1:0] out_mask,
  input logic           or_mask,
  input logic [NCH-1:0] stage1,
  input logic [NCH-1:0] stage2,
  input logic [NCH-1:0] ch_out,
  input logic           or_out,
  input logic           nor_out
);
  localparam int AGE_MAX = SYNC_STAGES + 4;

  logic       armed;
  logic [7:0] clr_age;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 clr_age <= 8'(AGE_MAX);
    else if (clear_in)       clr_age <= '0;
    else if (clr_age < 8'(AGE_MAX)) clr_age <= clr_age + 8'd1;
  end

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && (($past(stage1) & ~stage1) != '0)) |->
      ($past(clear_cmd) || (clr_age <= 8'(SYNC_STAGES + 1))));

  p_order_r3: assert property (@(posedge clk) disable iff (rst)
    (stage2 & ~stage1) == '0);

  p_mode_single_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(mode) && $past(out_set) == '0 && $past(out_mask) == '0) |->
      ch_out == $past(stage1));

  p_mode_double_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mode) && $past(out_set) == '0 && $past(out_mask) == '0) |->
      ch_out == $past(stage2));

  p_force_r8: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((ch_out & $past(out_set)) == $past(out_set)));

  p_suppress_r8: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((ch_out & $past(out_mask) & ~$past(out_set)) == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clear_cmd |=> (stage1 == '0 && stage2 == '0));

  p_ormask_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(or_mask)) |-> (!or_out && !nor_out));

  p_ornor_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(or_mask)) |-> ((or_out == (ch_out != '0)) && (nor_out == (ch_out == '0))));
endmodule

bind hit_capture_array hcap_checker #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) i_hcap_checker (
  .clk       (clk),
  .rst       (rst),
  .clear_in  (clear_in),
  .clear_cmd (clear_cmd),
  .mode      (mode),
  .out_set   (out_set),
  .out_mask  (out_mask),
  .or_mask   (or_mask),
  .stage1    (stage1),
  .stage2    (stage2),
  .ch_out    (ch_out),
  .or_out    (or_out),
  .nor_out   (nor_out)
);

// File: tb/test_hit_capture_array.sv
module test_hit_capture_array;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] hit_in = '0, in_mask = '0, sw_set_data = '0, out_set = '0, out_mask = '0;
  logic gate_in = 1'b0, clear_in = 1'b0, clear_cmd = 1'b0, gate_mask = 1'b1;
  logic sw_set_we = 1'b0, mode = 1'b0, or_mask = 1'b0;
  logic [NCH-1:0] stage1, stage2, ch_out;
  logic or_out, nor_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_capture_array #(.NCH(NCH), .SYNC_STAGES(2)) i_hit_capture_array (
    .clk(clk), .rst(rst), .hit_in(hit_in), .gate_in(gate_in), .clear_in(clear_in),
    .clear_cmd(clear_cmd), .in_mask(in_mask), .gate_mask(gate_mask),
    .sw_set_we(sw_set_we), .sw_set_data(sw_set_data), .mode(mode),
    .out_set(out_set), .out_mask(out_mask), .or_mask(or_mask),
    .stage1(stage1), .stage2(stage2), .ch_out(ch_out), .or_out(or_out), .nor_out(nor_out)
  );

  typedef struct packed {
    logic        m;
    logic        om;
    logic [15:0] os;
    logic [15:0] mk;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{m:1'b0, om:1'b0, os:16'h0000, mk:16'h0000},
    '{m:1'b1, om:1'b0, os:16'h0000, mk:16'h0000},
    '{m:1'b0, om:1'b0, os:16'hF000, mk:16'h000F},
    '{m:1'b1, om:1'b0, os:16'h0000, mk:16'h000F},
    '{m:1'b1, om:1'b1, os:16'h8000, mk:16'h0000},
    '{m:1'b0, om:1'b1, os:16'h0000, mk:16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hit(input logic [NCH-1:0] v);
    hit_in = v; cyc(2); hit_in = '0; cyc(4);
  endtask

  task automatic sw_write(input logic [NCH-1:0] v);
    sw_set_we = 1'b1; sw_set_data = v; cyc(1); sw_set_we = 1'b0; cyc(2);
  endtask

  task automatic do_clear;
    clear_cmd = 1'b1; cyc(1); clear_cmd = 1'b0; cyc(2);
  endtask

  initial begin
    int n = 0;
    while (!done && n < WATCHDOG) begin
      @(posedge clk); n++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", n, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 stage1", 32'(stage1), 0);
    chk("R1 stage2", 32'(stage2), 0);
    chk("R1 ch_out/or/nor", {14'(0), ch_out, or_out, nor_out}, 0);
    rst = 1'b0; cyc(2);
    chk("R10 nor idle", {30'(0), or_out, nor_out}, 32'h1);

    // R2 first hit
    hit(16'h00FF);
    chk("R2 stage1", 32'(stage1), 32'h00FF);
    chk("R2 stage2", 32'(stage2), 0);
    chk("R4 mode0 out", 32'(ch_out), 32'h00FF);
    // R3 second hit, then third
    hit(16'h000F);
    chk("R3 stage2", 32'(stage2), 32'h000F);
    hit(16'h0003);
    chk("R3 held stage2", 32'(stage2), 32'h000F);
    chk("R2 held stage1", 32'(stage1), 32'h00FF);

    // table walk: R4 R8 R10 R11
    for (int k = 0; k < 6; k++) begin
      logic [15:0] e;
      mode = TBL[k].m; or_mask = TBL[k].om; out_set = TBL[k].os; out_mask = TBL[k].mk;
      cyc(2);
      e = TBL[k].os | ((TBL[k].m ? 16'h000F : 16'h00FF) & ~TBL[k].mk);
      chk("R4/R8 ch_out", 32'(ch_out), 32'(e));
      chk("R10 or/nor", {30'(0), or_out, nor_out},
          {30'(0), ~TBL[k].om & (e != 0), ~TBL[k].om & (e == 0)});
      chk("R11 stages", {stage1, stage2}, {16'h00FF, 16'h000F});
    end
    mode = 1'b0; or_mask = 1'b0; out_set = '0; out_mask = '0;

    // R9 clear command
    do_clear();
    chk("R9 clear_cmd", {stage1, stage2}, 0);

    // R7 software set
    sw_write(16'h0100);
    chk("R7 sw first", 32'(stage1), 32'h0100);
    sw_write(16'h0100);
    chk("R7 sw repeat no hit", 32'(stage2), 0);
    sw_write(16'h0000);
    sw_write(16'h0100);
    chk("R7 sw second", 32'(stage2), 32'h0100);

    // R9 clear also empties sw vector
    do_clear();
    sw_write(16'h0100);
    chk("R9 sw vector cleared", {stage1, stage2}, {16'h0100, 16'h0000});
    clear_in = 1'b1; cyc(1); clear_in = 1'b0; cyc(4);
    chk("R9 clear_in", {stage1, stage2}, 0);

    // R5 input mask
    in_mask = 16'h00F0;
    hit(16'h00FF);
    chk("R5 masked hits", 32'(stage1), 32'h000F);
    sw_write(16'h0010);
    chk("R5 sw through mask", 32'(stage1), 32'h001F);
    in_mask = '0;
    do_clear();

    // R6 gate
    gate_mask = 1'b0; gate_in = 1'b0; cyc(3);
    hit(16'h0001);
    chk("R6 gate closed", 32'(stage1), 0);
    gate_in = 1'b1; cyc(3);
    hit(16'h0001);
    chk("R6 gate open", 32'(stage1), 32'h0001);
    gate_mask = 1'b1; gate_in = 1'b0; cyc(3);
    hit(16'h0002);
    chk("R6 gate ignored", 32'(stage1), 32'h0003);
    do_clear();

    // R9 clear beats simultaneous front-panel hit
    hit_in = 16'h0040; cyc(2); clear_cmd = 1'b1; cyc(1); clear_cmd = 1'b0; hit_in = '0; cyc(4);
    chk("R9 clear priority hw", 32'(stage1), 0);
    sw_set_we = 1'b1; sw_set_data = 16'h0080; clear_cmd = 1'b1; cyc(1);
    sw_set_we = 1'b0; clear_cmd = 1'b0; cyc(2);
    chk("R9 clear priority sw", 32'(stage1), 0);
    do_clear();

    // R12 simultaneous hw and sw hit counts once
    hit_in = 16'h0004; cyc(2); sw_set_we = 1'b1; sw_set_data = 16'h0004; cyc(1);
    sw_set_we = 1'b0; hit_in = '0; cyc(4);
    chk("R12 one hit", {stage1, stage2}, {16'h0004, 16'h0000});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule